// File: doc/BRIEF.md
# Stripmined Vector Sum Reducer

This block adds up an integer stream of a given length without a single serial accumulator. It keeps a bank of eight partial-sum registers. The incoming elements are spread across that bank in chunks. The first chunk is short and carries the length modulo eight. Every chunk after it is eight elements long. Each element of a chunk is added into the partial sum at its own slot. Once the last element has arrived, a folding phase runs. Each fold step halves the active width and adds the upper half of the bank into the lower half. The single remaining value is the total.

A user first hands over the element count on a command handshake. The block then takes exactly that many elements on a valid/ready data channel. After three fold cycles it presents the wrapped sum on a result port. The result stays there until it is accepted, and then the block becomes ready for the next command.

Top module: `vec_sum_reducer`

## Requirements
- R1: While reset is held and right after it, `cmd_ready` is 1, `in_ready` is 0 and `res_valid` is 0.
- R2: A command is taken only while `cmd_ready` is 1. All partial sums are cleared when a command is taken, so a result never contains data from an earlier operation. `cmd_valid` has no effect while the block is busy.
- R3: After a command with count N, `in_ready` stays 1 until exactly N elements have been accepted. It then drops in the cycle after the last handshake.
- R4: The first chunk holds N mod 8 elements when that value is nonzero. Every later chunk holds 8 elements.
- R5: The result equals the sum of all accepted elements modulo 2^W.
- R6: The fold takes exactly three steps. `res_valid` rises on the third clock edge after the edge that accepted the last element.
- R7: For N = 0, no element is accepted. The result is 0, and it becomes valid on the third edge after the command edge.
- R8: `res_valid` and `res_data` hold steady while `res_ready` is 0. The edge that sees `res_ready` high returns the block to `cmd_ready` = 1.
- R9: When N is a multiple of 8, there is no short chunk, and the result is still the full sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Element count offered |
| cmd_ready | output | 1 | Block idle, count can be taken |
| cmd_count | input | CW | Number of elements N |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Block accepts an element |
| in_data | input | W | Element value |
| res_valid | output | 1 | Total available |
| res_ready | input | 1 | Consumer takes the total |
| res_data | output | W | Wrapped total |

## Verification
The three port-visible symptoms below cover errors in the partial-sum slots, the clearing logic and the fold pairing, and each appears on the first result of an affected operation:

- A slot that is not cleared, or an element added twice or lost, shows up as a wrong `res_data` on the very next result.
- A wrong element counter shows up within one cycle as `in_ready` staying high or dropping early.
- A wrong fold count moves the rise of `res_valid` by whole cycles.

The reference model follows the handshakes on every clock. It therefore catches each of these at the first cycle where the ports differ.

// File: rtl/vec_sum_reducer.sv
module vec_sum_reducer #(
  parameter int W  = 16,
  parameter int VL = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [CW-1:0] cmd_count,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [W-1:0]  res_data
);
  localparam int IW = $clog2(VL);
  localparam int LW = IW + 1;
  localparam int HV = VL / 2;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_FOLD, S_DONE} st_t;

  st_t           state;
  logic [W-1:0]  part [VL];
  logic [CW-1:0] left;
  logic [IW-1:0] pos;
  logic [LW-1:0] clen;
  logic [LW-1:0] flen;
  logic [IW-1:0] rem;

  assign rem       = cmd_count[IW-1:0];
  assign cmd_ready = (state == S_IDLE);
  assign in_ready  = (state == S_ACC);
  assign res_valid = (state == S_DONE);
  assign res_data  = part[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      left  <= '0;
      pos   <= '0;
      clen  <= LW'(VL);
      flen  <= LW'(HV);
      for (int i = 0; i < VL; i++) part[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          for (int i = 0; i < VL; i++) part[i] <= '0;
          left  <= cmd_count;
          pos   <= '0;
          clen  <= (rem == '0) ? LW'(VL) : {1'b0, rem};
          flen  <= LW'(HV);
          state <= (cmd_count == '0) ? S_FOLD : S_ACC;
        end
        S_ACC: if (in_valid) begin
          part[pos] <= part[pos] + in_data;
          left      <= left - 1'b1;
          if ({1'b0, pos} == clen - 1'b1) begin
            pos  <= '0;
            clen <= LW'(VL);
          end else begin
            pos <= pos + 1'b1;
          end
          if (left == CW'(1)) state <= S_FOLD;
        end
        S_FOLD: begin
          for (int i = 0; i < HV; i++)
            if (LW'(i) < flen) part[i] <= part[i] + part[i + int'(flen)];
          flen <= flen >> 1;
          if (flen == LW'(1)) state <= S_DONE;
        end
        S_DONE: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vec_sum_reducer_chk.sv
module vec_sum_reducer_chk #(
  parameter int W  = 16,
  parameter int VL = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [CW-1:0] cmd_count,
  input logic          in_valid,
  input logic          in_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [W-1:0]  res_data,
  input logic [CW-1:0] left,
  input logic [$clog2(VL):0] clen,
  input logic          fold_last
);
  localparam int IW = $clog2(VL);

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data)); // R8
  AST_RES_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> cmd_ready); // R8
  AST_CLEAR_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> res_data == '0); // R2
  AST_SHORT_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_count[IW-1:0] != '0 |=> clen == {1'b0, $past(cmd_count[IW-1:0])}); // R4
  AST_FULL_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_count[IW-1:0] == '0 |=> clen == ($clog2(VL)+1)'(VL)); // R9
  AST_LAST_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && left == CW'(1) |=> !in_ready); // R3
  AST_EMPTY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_count == '0 |=> !in_ready); // R7
  AST_FOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
    fold_last |=> res_valid); // R6
  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, in_ready, res_valid})); // R1
endmodule

bind vec_sum_reducer vec_sum_reducer_chk #(.W(W), .VL(VL), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_count(cmd_count), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .left(left), .clen(clen), .fold_last(state == S_FOLD && flen == 1));

// File: tb/tb_vec_sum_reducer.sv
module tb_vec_sum_reducer;
  localparam int W = 16;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, in_valid = 0, res_ready = 0;
  logic [CW-1:0] cmd_count = '0;
  logic [W-1:0] in_data = '0;
  logic cmd_ready, in_ready, res_valid;
  logic [W-1:0] res_data;

  int checks = 0, errors = 0, cycles = 0;
  int m_mode = 0, m_left = 0, m_fold = 0;
  logic [W-1:0] m_sum = '0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_sum_reducer #(.W(W), .VL(8), .CW(CW)) dut (.*);

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) m_mode = 0;
    else case (m_mode)
      0: if (cmd_valid) begin
           m_left = int'(cmd_count); m_sum = '0; m_fold = 0;
           m_mode = (cmd_count == 0) ? 2 : 1;
         end
      1: if (in_valid) begin
           m_sum = m_sum + in_data; m_left--;
           if (m_left == 0) begin m_mode = 2; m_fold = 0; end
         end
      2: begin m_fold++; if (m_fold == 3) m_mode = 3; end
      default: if (res_ready) m_mode = 0;
    endcase
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 cmd_ready", {15'b0, cmd_ready}, {15'b0, m_mode == 0});
    chk("R3 in_ready", {15'b0, in_ready}, {15'b0, m_mode == 1});
    chk("R6 res_valid", {15'b0, res_valid}, {15'b0, m_mode == 3});
    if (m_mode == 3) chk("R5 res_data", res_data, m_sum);
  end

  always @(posedge clk) if (cycles > 150000 && !done) begin
    done = 1; errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic run_op(string tag, int n, int seed, int stall);
    logic [W-1:0] exp = '0;
    bit acc;
    @(negedge clk); cmd_valid = 1; cmd_count = CW'(n);
    @(negedge clk); cmd_valid = 0;
    for (int k = 0; k < n; k++) begin
      acc = 0;
      while (!acc) begin
        if (k > 0 || !acc) ;
        in_valid = ((k + seed) % 5) != 0 || ($time % 3 == 0);
        in_data  = W'(k * 4099 + seed * 31337 + 60000);
        if (k == 2 && seed == 7) cmd_valid = 1;  // R2: ignored while busy
        acc = in_valid && in_ready;
        if (acc) exp = exp + in_data;
        @(negedge clk);
        cmd_valid = 0;
      end
    end
    in_valid = 0;
    while (!res_valid) @(negedge clk);
    chk(tag, res_data, exp);
    repeat (stall) @(negedge clk);
    chk("R8 held", res_data, exp);
    res_ready = 1;
    @(negedge clk); res_ready = 0;
    chk("R8 back to idle", {15'b0, cmd_ready}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmd_ready", {15'b0, cmd_ready}, 16'd1);
    chk("R1 in_ready", {15'b0, in_ready}, 16'd0);
    chk("R1 res_valid", {15'b0, res_valid}, 16'd0);
    rst_n = 1;
    run_op("R5 n=5", 5, 1, 2);
    run_op("R4 n=13", 13, 2, 0);
    run_op("R9 n=8", 8, 3, 1);
    run_op("R9 n=16", 16, 4, 3);
    run_op("R7 n=0", 0, 5, 2);
    run_op("R2 after empty n=1", 1, 6, 0);
    run_op("R4 n=23 busy cmd", 23, 7, 1);
    run_op("R5 n=200 wrap", 200, 8, 4);
    run_op("R3 n=7", 7, 9, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule